// File: doc/BRIEF.md
# PCIe Root Port Error Aggregator

This block gathers error events for a PCI Express root port and decides what each one causes. Events come as one-cycle decoded strobes from two sources: error messages received from downstream devices (fatal, non-fatal, correctable), and error conditions that the port detects in itself. The port's own uncorrectable conditions each carry a mask bit and a severity bit that picks fatal or non-fatal. Its correctable conditions each carry a mask bit. A masked condition has no effect at all.

Each event lands in one of three severity classes. A class event sets a sticky status bit, which software clears by writing 1. A second event while the bit is already set raises a "multiple" flag. A level interrupt follows the status bits that have their class interrupt enable set. Upstream error message requests are queued per class and leave through a valid/ready handshake in fixed priority order.

One system-error enable governs two things: the upstream reporting of the port's own uncorrectable errors, and the forwarding of received fatal and non-fatal messages. Correctable traffic never looks at that enable.

Top module: `rp_err_agg`

## Requirements
- R1: An unmasked own uncorrectable condition i is classed fatal when `unc_sev_i[i]` is 1 and non-fatal when it is 0. Every unmasked own correctable condition is classed correctable. Class status bits are `sts_o[2]` fatal, `sts_o[1]` non-fatal and `sts_o[0]` correctable. A class status bit reads 1 at the first falling edge after the rising edge that samples the event.
- R2: A condition whose bit is set in `unc_mask_i` or `cor_mask_i` sets no status bit and produces no upstream message.
- R3: A class status bit stays set until a 1 is written to the same position of `sts_clr_i`. When an event and a clear of the same bit arrive in one cycle, the bit ends up set.
- R4: An event of a class whose status bit is already set also sets that class's multiple flag. The flags are `sts_o[5]` fatal, `sts_o[4]` non-fatal and `sts_o[3]` correctable, and each is cleared by writing 1 to the same bit of `sts_clr_i`.
- R5: `irq_o` is high exactly when, one cycle earlier, some class status bit in `sts_o[2:0]` was set with its enable set in `rt_en_i`. The enable bits are 2 fatal, 1 non-fatal and 0 correctable. `irq_o` falls one cycle after the last enabled status bit is cleared.
- R6: An own fatal or non-fatal event requests an upstream message when its class bit in `dev_en_i` (2 fatal, 1 non-fatal) is set, or when `serr_en_i` is set.
- R7: A received fatal or non-fatal message is forwarded upstream only when `serr_en_i` is set. `dev_en_i` has no effect on it.
- R8: A correctable event, own or received, requests an upstream message exactly when `dev_en_i[0]` is set. `serr_en_i` has no effect on it.
- R9: A message request appears on `msg_valid_o` one cycle after the request is registered. Class codes are 2 fatal, 1 non-fatal and 0 correctable. While `msg_valid_o` is high and `msg_ready_i` is low, both `msg_valid_o` and `msg_class_o` hold.
- R10: Requests pending in the same cycle leave in the order fatal, non-fatal, correctable.
- R11: Repeated requests of one class, made while a request of that class is still waiting to be presented, produce a single message.
- R12: After reset all status bits, `irq_o` and `msg_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_fatal_i | input | 1 | Received fatal error message strobe |
| rx_nonfatal_i | input | 1 | Received non-fatal error message strobe |
| rx_cor_i | input | 1 | Received correctable error message strobe |
| own_unc_i | input | N_UNC | Own uncorrectable condition strobes |
| own_cor_i | input | N_COR | Own correctable condition strobes |
| unc_mask_i | input | N_UNC | Uncorrectable condition masks, 1 = masked |
| unc_sev_i | input | N_UNC | Uncorrectable severity, 1 = fatal |
| cor_mask_i | input | N_COR | Correctable condition masks, 1 = masked |
| rt_en_i | input | 3 | Per-class interrupt enables {fatal, non-fatal, correctable} |
| dev_en_i | input | 3 | Per-class upstream report enables {fatal, non-fatal, correctable} |
| serr_en_i | input | 1 | System-error enable for uncorrectable reporting and forwarding |
| sts_clr_i | input | 6 | Write-1-to-clear strobes for the status bits |
| sts_o | output | 6 | {multiple flags[2:0], class status[2:0]} |
| irq_o | output | 1 | Level interrupt to the CPU |
| msg_valid_o | output | 1 | Upstream message request valid |
| msg_class_o | output | 2 | Upstream message class code |
| msg_ready_i | input | 1 | Upstream message accepted |

## Verification
A strobe sampled at rising edge k shows up in `sts_o` right after edge k. It reaches `irq_o` after edge k+1. It appears on `msg_valid_o` after edge k+1, provided the output stage is free. The bench drives inputs and reads outputs on falling edges, so each check sits at the first falling edge after the register stage that should have moved. Checks of the interrupt taking effect or clearing are placed one falling edge before and one after the expected change. Message traffic is recorded at every accepting rising edge and compared in order once the ready drain has run long enough to empty every pending class.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;
  localparam int NUM_CLASS = 3;
  localparam int STS_W     = 2 * NUM_CLASS;
  localparam int CLS_W     = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_COR      = 2'd0,
    CLS_NONFATAL = 2'd1,
    CLS_FATAL    = 2'd2
  } err_class_e;
endpackage

// File: rtl/rp_rst_sync.sv
module rp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rp_err_classify.sv
// Masks the port's own conditions and folds them into class hits.
module rp_err_classify
  import rp_err_pkg::*;
#(
  parameter int N_UNC = 4,
  parameter int N_COR = 4
) (
  input  logic [N_UNC-1:0]     own_unc_i,
  input  logic [N_COR-1:0]     own_cor_i,
  input  logic [N_UNC-1:0]     unc_mask_i,
  input  logic [N_UNC-1:0]     unc_sev_i,
  input  logic [N_COR-1:0]     cor_mask_i,
  output logic [NUM_CLASS-1:0] hit_o
);
  logic [N_UNC-1:0] unc_live;
  logic [N_UNC-1:0] unc_to_fatal;
  logic [N_UNC-1:0] unc_to_nf;
  logic [N_COR-1:0] cor_live;

  for (genvar i = 0; i < N_UNC; i++) begin : g_unc
    always_comb begin
      unc_live[i]     = own_unc_i[i] & ~unc_mask_i[i];
      unc_to_fatal[i] = unc_live[i] &  unc_sev_i[i];
      unc_to_nf[i]    = unc_live[i] & ~unc_sev_i[i];
    end
  end

  for (genvar j = 0; j < N_COR; j++) begin : g_cor
    always_comb begin
      cor_live[j] = own_cor_i[j] & ~cor_mask_i[j];
    end
  end

  always_comb begin
    hit_o                = '0;
    hit_o[int'(CLS_FATAL)]    = |unc_to_fatal;
    hit_o[int'(CLS_NONFATAL)] = |unc_to_nf;
    hit_o[int'(CLS_COR)]      = |cor_live;
  end
endmodule

// File: rtl/rp_err_status.sv
// Sticky per-class status with multiple flags and the level interrupt.
module rp_err_status
  import rp_err_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CLASS-1:0] evt_i,
  input  logic [STS_W-1:0]     clr_i,
  input  logic [NUM_CLASS-1:0] irq_en_i,
  output logic [STS_W-1:0]     sts_o,
  output logic                 irq_o
);
  logic [NUM_CLASS-1:0] pend_q, pend_d;
  logic [NUM_CLASS-1:0] multi_q, multi_d;
  logic                 irq_q, irq_d;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    always_comb begin
      pend_d[c]  = evt_i[c] | (pend_q[c] & ~clr_i[c]);
      multi_d[c] = (evt_i[c] & pend_q[c]) |
                   (multi_q[c] & ~clr_i[NUM_CLASS + c]);
    end
  end

  always_comb begin
    irq_d = |(pend_q & irq_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      multi_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      multi_q <= multi_d;
      irq_q   <= irq_d;
    end
  end

  assign sts_o = {multi_q, pend_q};
  assign irq_o = irq_q;
endmodule

// File: rtl/rp_err_msgq.sv
// Per-class coalescing request flags feeding one valid/ready output stage.
module rp_err_msgq
  import rp_err_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CLASS-1:0] req_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [CLS_W-1:0]     class_o
);
  logic [NUM_CLASS-1:0] pend_q, pend_d;
  logic [NUM_CLASS-1:0] grant;
  logic [NUM_CLASS-1:0] take;
  logic [CLS_W-1:0]     sel_code;
  logic                 valid_q, valid_d;
  logic [CLS_W-1:0]     class_q, class_d;
  logic                 load;

  // Highest class index wins: fatal, then non-fatal, then correctable.
  always_comb begin
    grant    = '0;
    sel_code = '0;
    for (int c = NUM_CLASS - 1; c >= 0; c--) begin
      if (pend_q[c] && (grant == '0)) begin
        grant[c] = 1'b1;
        sel_code = CLS_W'(c);
      end
    end
  end

  always_comb begin
    load    = ~valid_q | ready_i;
    take    = load ? grant : '0;
    pend_d  = req_i | (pend_q & ~take);
    valid_d = load ? (|pend_q) : valid_q;
    class_d = sel_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      class_q <= '0;
    end else begin
      pend_q  <= pend_d;
      valid_q <= valid_d;
      if (load) class_q <= class_d;
    end
  end

  assign valid_o = valid_q;
  assign class_o = class_q;
endmodule

// File: rtl/rp_err_agg.sv
module rp_err_agg
  import rp_err_pkg::*;
#(
  parameter int N_UNC = 4,
  parameter int N_COR = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_fatal_i,
  input  logic                 rx_nonfatal_i,
  input  logic                 rx_cor_i,
  input  logic [N_UNC-1:0]     own_unc_i,
  input  logic [N_COR-1:0]     own_cor_i,
  input  logic [N_UNC-1:0]     unc_mask_i,
  input  logic [N_UNC-1:0]     unc_sev_i,
  input  logic [N_COR-1:0]     cor_mask_i,
  input  logic [NUM_CLASS-1:0] rt_en_i,
  input  logic [NUM_CLASS-1:0] dev_en_i,
  input  logic                 serr_en_i,
  input  logic [STS_W-1:0]     sts_clr_i,
  output logic [STS_W-1:0]     sts_o,
  output logic                 irq_o,
  output logic                 msg_valid_o,
  output logic [CLS_W-1:0]     msg_class_o,
  input  logic                 msg_ready_i
);
  localparam int IF = int'(CLS_FATAL);
  localparam int IN = int'(CLS_NONFATAL);
  localparam int IC = int'(CLS_COR);

  logic                 rst_int_n;
  logic [NUM_CLASS-1:0] own_hit;
  logic [NUM_CLASS-1:0] rx_hit;
  logic [NUM_CLASS-1:0] cls_evt;
  logic [NUM_CLASS-1:0] up_req;

  rp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  rp_err_classify #(.N_UNC(N_UNC), .N_COR(N_COR)) u_cls (
    .own_unc_i  (own_unc_i),
    .own_cor_i  (own_cor_i),
    .unc_mask_i (unc_mask_i),
    .unc_sev_i  (unc_sev_i),
    .cor_mask_i (cor_mask_i),
    .hit_o      (own_hit)
  );

  // Class events and upstream routing.
  always_comb begin
    rx_hit     = '0;
    rx_hit[IF] = rx_fatal_i;
    rx_hit[IN] = rx_nonfatal_i;
    rx_hit[IC] = rx_cor_i;
    cls_evt    = rx_hit | own_hit;

    up_req     = '0;
    up_req[IF] = (rx_hit[IF] & serr_en_i) |
                 (own_hit[IF] & (dev_en_i[IF] | serr_en_i));
    up_req[IN] = (rx_hit[IN] & serr_en_i) |
                 (own_hit[IN] & (dev_en_i[IN] | serr_en_i));
    up_req[IC] = cls_evt[IC] & dev_en_i[IC];
  end

  rp_err_status u_sts (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt_i    (cls_evt),
    .clr_i    (sts_clr_i),
    .irq_en_i (rt_en_i),
    .sts_o    (sts_o),
    .irq_o    (irq_o)
  );

  rp_err_msgq u_msg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (up_req),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .class_o (msg_class_o)
  );
endmodule

// File: rtl/rp_err_agg_chk.sv
module rp_err_agg_chk
  import rp_err_pkg::*;
#(
  parameter int N_COR = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_nonfatal_i,
  input logic                 rx_cor_i,
  input logic [N_COR-1:0]     own_cor_i,
  input logic [N_COR-1:0]     cor_mask_i,
  input logic [NUM_CLASS-1:0] rt_en_i,
  input logic [STS_W-1:0]     sts_clr_i,
  input logic [STS_W-1:0]     sts_o,
  input logic                 irq_o,
  input logic                 msg_valid_o,
  input logic [CLS_W-1:0]     msg_class_o,
  input logic                 msg_ready_i
);
  // R5: interrupt level tracks enabled status one cycle later
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (($past(sts_o[2:0]) & $past(rt_en_i)) != '0)));

  // R9: a stalled message holds valid and class
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_class_o)));

  // R9: only defined class codes are presented
  a_r9_code: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> (msg_class_o != 2'b11));

  // R3: status bits are sticky without a clear
  a_r3_sticky_cor: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[0] && !sts_clr_i[0]) |=> sts_o[0]);

  a_r3_sticky_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[2] && !sts_clr_i[2]) |=> sts_o[2]);

  // R2: masked correctable conditions leave the status clear
  a_r2_cor_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_o[0] && !rx_cor_i && ((own_cor_i & ~cor_mask_i) == '0)) |=> !sts_o[0]);

  // R4: a repeat of a set class raises the multiple flag
  a_r4_multi_nf: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[1] && rx_nonfatal_i) |=> sts_o[4]);
endmodule

bind rp_err_agg rp_err_agg_chk #(.N_COR(N_COR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_nonfatal_i (rx_nonfatal_i),
  .rx_cor_i      (rx_cor_i),
  .own_cor_i     (own_cor_i),
  .cor_mask_i    (cor_mask_i),
  .rt_en_i       (rt_en_i),
  .sts_clr_i     (sts_clr_i),
  .sts_o         (sts_o),
  .irq_o         (irq_o),
  .msg_valid_o   (msg_valid_o),
  .msg_class_o   (msg_class_o),
  .msg_ready_i   (msg_ready_i)
);

// File: tb/tb_rp_err_agg.sv
`timescale 1ns/1ps
module tb_rp_err_agg;
  logic       clk;
  logic       rst_n;
  logic       rx_fatal_i, rx_nonfatal_i, rx_cor_i;
  logic [3:0] own_unc_i, own_cor_i, unc_mask_i, unc_sev_i, cor_mask_i;
  logic [2:0] rt_en_i, dev_en_i;
  logic       serr_en_i;
  logic [5:0] sts_clr_i;
  logic [5:0] sts_o;
  logic       irq_o;
  logic       msg_valid_o;
  logic [1:0] msg_class_o;
  logic       msg_ready_i;

  int n_chk = 0;
  int n_err = 0;
  int mcnt  = 0;
  logic [1:0] mlog [8];
  bit done = 0;

  rp_err_agg #(.N_UNC(4), .N_COR(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_fatal_i(rx_fatal_i), .rx_nonfatal_i(rx_nonfatal_i), .rx_cor_i(rx_cor_i),
    .own_unc_i(own_unc_i), .own_cor_i(own_cor_i),
    .unc_mask_i(unc_mask_i), .unc_sev_i(unc_sev_i), .cor_mask_i(cor_mask_i),
    .rt_en_i(rt_en_i), .dev_en_i(dev_en_i), .serr_en_i(serr_en_i),
    .sts_clr_i(sts_clr_i), .sts_o(sts_o), .irq_o(irq_o),
    .msg_valid_o(msg_valid_o), .msg_class_o(msg_class_o), .msg_ready_i(msg_ready_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Message recorder: one entry per accepting edge.
  always @(posedge clk) begin
    if (rst_n && msg_valid_o && msg_ready_i) begin
      if (mcnt < 8) mlog[mcnt] = msg_class_o;
      mcnt = mcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic f, input logic nf, input logic c,
                       input logic [3:0] ou, input logic [3:0] oc, input logic [5:0] clr);
    rx_fatal_i = f; rx_nonfatal_i = nf; rx_cor_i = c;
    own_unc_i = ou; own_cor_i = oc; sts_clr_i = clr;
    @(negedge clk);
    rx_fatal_i = 0; rx_nonfatal_i = 0; rx_cor_i = 0;
    own_unc_i = '0; own_cor_i = '0; sts_clr_i = '0;
  endtask

  task automatic expect_msgs(input string req, input int n,
                             input logic [1:0] e0, input logic [1:0] e1, input logic [1:0] e2);
    logic [1:0] ev [3];
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    msg_ready_i = 1'b1;
    step(8);
    msg_ready_i = 1'b0;
    chk(req, mcnt, n);
    for (int i = 0; i < n && i < 3; i++) chk(req, mlog[i], ev[i]);
    mcnt = 0;
  endtask

  task automatic clean();
    sts_clr_i = 6'h3f;
    msg_ready_i = 1'b1;
    @(negedge clk);
    sts_clr_i = '0;
    step(6);
    msg_ready_i = 1'b0;
    mcnt = 0;
  endtask

  task automatic t_reset();
    chk("R12 status", sts_o, 6'h00);
    chk("R12 irq", irq_o, 1'b0);
    chk("R12 valid", msg_valid_o, 1'b0);
  endtask

  task automatic t_classify();
    dev_en_i = 3'b111; serr_en_i = 0; unc_sev_i = 4'b0010;
    pulse(0, 0, 0, 4'b0010, 4'b0000, 6'h0);
    chk("R1 fatal severity", sts_o, 6'b000100);
    pulse(0, 0, 0, 4'b0001, 4'b0000, 6'h0);
    chk("R1 nonfatal severity", sts_o, 6'b000110);
    pulse(0, 0, 0, 4'b0000, 4'b0001, 6'h0);
    chk("R1 correctable", sts_o, 6'b000111);
    expect_msgs("R6 R8 own reports", 3, 2'd2, 2'd1, 2'd0);
    clean();
  endtask

  task automatic t_mask();
    dev_en_i = 3'b111; serr_en_i = 1; unc_sev_i = 4'b0000;
    unc_mask_i = 4'b0100; cor_mask_i = 4'b0010;
    pulse(0, 0, 0, 4'b0100, 4'b0010, 6'h0);
    chk("R2 masked status", sts_o, 6'h00);
    expect_msgs("R2 masked message", 0, 2'd0, 2'd0, 2'd0);
    pulse(0, 0, 0, 4'b1000, 4'b0000, 6'h0);
    chk("R2 unmasked neighbour", sts_o, 6'b000010);
    unc_mask_i = '0; cor_mask_i = '0;
    clean();
  endtask

  task automatic t_sticky();
    dev_en_i = 3'b000; serr_en_i = 0;
    pulse(0, 0, 1, 4'h0, 4'h0, 6'h0);
    chk("R3 set", sts_o, 6'b000001);
    step(3);
    chk("R3 held", sts_o, 6'b000001);
    pulse(0, 0, 0, 4'h0, 4'h0, 6'b000001);
    chk("R3 cleared", sts_o, 6'h00);
    pulse(0, 0, 1, 4'h0, 4'h0, 6'b000001);
    chk("R3 set beats clear", sts_o, 6'b000001);
    clean();
  endtask

  task automatic t_multi();
    dev_en_i = 3'b000; serr_en_i = 0;
    pulse(0, 1, 0, 4'h0, 4'h0, 6'h0);
    chk("R4 first", sts_o, 6'b000010);
    pulse(0, 1, 0, 4'h0, 4'h0, 6'h0);
    chk("R4 multiple", sts_o, 6'b010010);
    pulse(0, 0, 0, 4'h0, 4'h0, 6'b010000);
    chk("R4 clear flag", sts_o, 6'b000010);
    clean();
  endtask

  task automatic t_irq();
    dev_en_i = 3'b000; serr_en_i = 0; rt_en_i = 3'b001;
    pulse(0, 0, 1, 4'h0, 4'h0, 6'h0);
    chk("R5 not yet", irq_o, 1'b0);
    step(1);
    chk("R5 raised", irq_o, 1'b1);
    pulse(0, 0, 0, 4'h0, 4'h0, 6'b000001);
    chk("R5 still high", irq_o, 1'b1);
    step(1);
    chk("R5 dropped", irq_o, 1'b0);
    rt_en_i = 3'b100;
    pulse(0, 0, 1, 4'h0, 4'h0, 6'h0);
    step(2);
    chk("R5 class disabled", irq_o, 1'b0);
    rt_en_i = 3'b000;
    clean();
  endtask

  task automatic t_forward();
    dev_en_i = 3'b111; serr_en_i = 0;
    pulse(1, 1, 0, 4'h0, 4'h0, 6'h0);
    expect_msgs("R7 blocked", 0, 2'd0, 2'd0, 2'd0);
    serr_en_i = 1;
    pulse(1, 0, 0, 4'h0, 4'h0, 6'h0);
    expect_msgs("R7 forwarded", 1, 2'd2, 2'd0, 2'd0);
    clean();
  endtask

  task automatic t_route();
    unc_sev_i = 4'b0010;
    dev_en_i = 3'b000; serr_en_i = 1;
    pulse(0, 0, 0, 4'b0010, 4'h0, 6'h0);
    expect_msgs("R6 via serr", 1, 2'd2, 2'd0, 2'd0);
    pulse(0, 0, 0, 4'h0, 4'b0001, 6'h0);
    expect_msgs("R8 serr ignored", 0, 2'd0, 2'd0, 2'd0);
    dev_en_i = 3'b001; serr_en_i = 0;
    pulse(0, 0, 1, 4'h0, 4'h0, 6'h0);
    expect_msgs("R8 received cor", 1, 2'd0, 2'd0, 2'd0);
    clean();
  endtask

  task automatic t_priority();
    dev_en_i = 3'b001; serr_en_i = 1;
    pulse(1, 1, 1, 4'h0, 4'h0, 6'h0);
    chk("R9 not yet valid", msg_valid_o, 1'b0);
    step(1);
    chk("R9 valid", msg_valid_o, 1'b1);
    chk("R10 fatal first", msg_class_o, 2'd2);
    step(3);
    chk("R9 held valid", msg_valid_o, 1'b1);
    chk("R9 held class", msg_class_o, 2'd2);
    expect_msgs("R10 order", 3, 2'd2, 2'd1, 2'd0);
    clean();
  endtask

  task automatic t_coalesce();
    dev_en_i = 3'b001; serr_en_i = 1;
    pulse(1, 0, 0, 4'h0, 4'h0, 6'h0);
    step(1);
    rx_cor_i = 1;
    step(3);
    rx_cor_i = 0;
    expect_msgs("R11 coalesced", 2, 2'd2, 2'd0, 2'd0);
    clean();
  endtask

  initial begin
    rst_n = 0;
    rx_fatal_i = 0; rx_nonfatal_i = 0; rx_cor_i = 0;
    own_unc_i = '0; own_cor_i = '0; unc_mask_i = '0; unc_sev_i = '0; cor_mask_i = '0;
    rt_en_i = '0; dev_en_i = '0; serr_en_i = 0; sts_clr_i = '0; msg_ready_i = 0;
    step(3);
    rst_n = 1;
    step(3);
    t_reset();
    t_classify();
    t_mask();
    t_sticky();
    t_multi();
    t_irq();
    t_forward();
    t_route();
    t_priority();
    t_coalesce();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog all act=%0h exp=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule